// File: doc/BRIEF.md
# SPI Target Receive Buffer with Level and Chip-Select Events

This block is the serial front end of a host command channel. An external SPI controller selects the target and clocks bytes in on MOSI, in mode 0 and MSB first. Each complete byte lands in a 128-byte input buffer. At the same time, the bytes that the local CPU wrote into a 128-byte output buffer leave on MISO. Chip select, SCLK and MOSI are asynchronous to the block. Each one goes through a two-flop synchronizer in the system clock domain before any edge is detected.

The CPU sees four maskable events. Two of them come from chip select: one when the host selects the target and one when it releases it. The release event is raised even when no SCLK edge arrived while the target was selected. The other two come from the transfer pointer: one when it reaches the half-buffer mark and one when it reaches a programmable level. That level is normally set to the size of a command header, so that software can parse the header early. A single interrupt line reports any pending event whose enable bit is set. The CPU reaches the buffers and the registers through a simple read/write port. A read returns its data one clock after the read strobe.

Top module: `spi_tgt_evt`

## Requirements
- R1: After reset the event status register (0x100) reads 0x00, the enable register (0x101) reads 0x00, the level register (0x102) reads 0x80, the state register (0x103) reads 0x00 and `irq` is low.
- R2: While chip select is low, each SCLK rising edge samples MOSI, MSB first. After the eighth edge the byte is written into the input buffer at the transfer pointer and the pointer advances by one. The CPU reads input byte n at address 0x080+n.
- R3: After byte 127 the transfer pointer wraps to 0, so a later byte overwrites input location 0 onward.
- R4: A chip-select falling edge clears the transfer pointer and the bit counter, which discards a partial byte. It also sets status bit 2.
- R5: A chip-select rising edge sets status bit 1, including a select window in which SCLK never toggled.
- R6: Status bit 3 is set whenever a committed byte brings the transfer pointer to 64.
- R7: Level register bits [5:0] hold a threshold and bit 7 is a disable. While bit 7 is 0 and the threshold is nonzero, status bit 0 is set when a committed byte brings the pointer to the threshold. A threshold of 0, or bit 7 set to 1, never sets bit 0.
- R8: Writing 0x100 clears each status bit written as 1 and leaves each bit written as 0 unchanged. An event in the same clock as the clear wins.
- R9: `irq` is driven from a register and goes high one clock after any status bit is set whose enable bit is set. The enable bits sit at the same positions as the status bits.
- R10: State register bit 7 reads 1 while the synchronized chip select is low. Bits [6:0] read the transfer pointer.
- R11: MISO carries the output-buffer byte at the transfer pointer, MSB first. The CPU writes output byte n at address 0x000+n. Each bit is valid before the SCLK rising edge that samples it, and the pointer wraps at 128.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Chip select from the host, active low, asynchronous |
| spi_sclk | input | 1 | Serial clock from the host, asynchronous |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, registered |
| cpu_addr | input | 9 | CPU address: output buffer, input buffer or registers |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write strobe |
| cpu_re | input | 1 | CPU read strobe |
| cpu_rdata | output | 8 | CPU read data, valid one clock after `cpu_re` |
| irq | output | 1 | Interrupt: OR of enabled pending events |

## Verification
The bench targets the select window that carries no clocks. A design that raised the release event only at the end of a byte would leave status bit 1 clear there. It also opens a fresh select after a three-bit fragment, where a design that kept the bit counter would store a byte shifted by three. The programmable level is driven at threshold 8, at threshold 0 and with the disable bit set. A design with a wrong comparison, or one that ignores the disable bit, would raise bit 0 on those patterns. A 130-byte transfer checks the half mark, the pointer wrap and the MISO wrap together. Write-one-to-clear is tested with an all-zero write, and the interrupt is tested against enable masking every clock.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;
  localparam int unsigned NUM_EVT = 4;
  localparam int unsigned EV_LVL2 = 0;
  localparam int unsigned EV_DESEL = 1;
  localparam int unsigned EV_SEL = 2;
  localparam int unsigned EV_HALF = 3;

  typedef enum logic [1:0] {
    RGN_OBUF = 2'b00,
    RGN_IBUF = 2'b01,
    RGN_REGS = 2'b10,
    RGN_NONE = 2'b11
  } rgn_e;

  typedef enum logic [1:0] {
    RS_STATUS = 2'd0,
    RS_ENABLE = 2'd1,
    RS_LEVEL  = 2'd2,
    RS_STATE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n_pin,
  input  logic sclk_pin,
  input  logic mosi_pin,
  output logic cs_n_q,
  output logic cs_fall,
  output logic cs_rise,
  output logic sclk_rise,
  output logic mosi_q
);
  logic [STAGES-1:0] cs_p, ck_p, mo_p;
  logic cs_d, ck_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_p <= '1;
      ck_p <= '0;
      mo_p <= '0;
      cs_d <= 1'b1;
      ck_d <= 1'b0;
    end else begin
      cs_p <= {cs_p[STAGES-2:0], cs_n_pin};
      ck_p <= {ck_p[STAGES-2:0], sclk_pin};
      mo_p <= {mo_p[STAGES-2:0], mosi_pin};
      cs_d <= cs_p[STAGES-1];
      ck_d <= ck_p[STAGES-1];
    end
  end

  assign cs_n_q    = cs_p[STAGES-1];
  assign mosi_q    = mo_p[STAGES-1];
  assign cs_fall   = cs_d & ~cs_p[STAGES-1];
  assign cs_rise   = ~cs_d & cs_p[STAGES-1];
  assign sclk_rise = ~ck_d & ck_p[STAGES-1];
endmodule

// File: rtl/spi_tgt_shift.sv
module spi_tgt_shift #(
  parameter int DEPTH = 128,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n_q,
  input  logic             cs_fall,
  input  logic             sclk_rise,
  input  logic             mosi_q,
  input  logic [7:0]       ob_byte,
  output logic [PTR_W-1:0] ptr,
  output logic [PTR_W-1:0] ptr_nxt,
  output logic             commit,
  output logic [7:0]       rx_byte,
  output logic             miso
);
  logic [2:0] bitcnt;
  logic [6:0] shreg;
  logic       clk_in;

  assign clk_in  = ~cs_n_q & sclk_rise & ~cs_fall;
  assign commit  = clk_in & (bitcnt == 3'd7);
  assign rx_byte = {shreg, mosi_q};
  assign ptr_nxt = (ptr == PTR_W'(DEPTH - 1)) ? '0 : ptr + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || cs_fall) begin
      bitcnt <= '0;
      shreg  <= '0;
      ptr    <= '0;
    end else if (clk_in) begin
      bitcnt <= bitcnt + 1'b1;
      shreg  <= rx_byte[6:0];
      if (commit) ptr <= ptr_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) miso <= 1'b0;
    else     miso <= ob_byte[3'd7 - bitcnt];
  end

  p_ptr_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (commit && ptr == PTR_W'(DEPTH - 1)) |=> (ptr == '0));
  p_sel_clears_r4: assert property (@(posedge clk) disable iff (rst)
    cs_fall |=> (ptr == '0 && bitcnt == 3'd0));
  p_ptr_moves_only_on_byte_r2: assert property (@(posedge clk) disable iff (rst)
    (!commit && !cs_fall) |=> $stable(ptr));
endmodule

// File: rtl/spi_tgt_events.sv
module spi_tgt_events
  import spi_tgt_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int LVL_W = 6,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cs_fall,
  input  logic               cs_rise,
  input  logic               commit,
  input  logic [PTR_W-1:0]   ptr_nxt,
  input  logic               we_sts,
  input  logic               we_en,
  input  logic               we_lvl,
  input  logic [NUM_EVT-1:0] mask_wdata,
  input  logic [7:0]         lvl_wdata,
  output logic [NUM_EVT-1:0] sts,
  output logic [NUM_EVT-1:0] en,
  output logic [7:0]         lvl_cfg,
  output logic               irq
);
  localparam logic [PTR_W-1:0] HALF_PTR = PTR_W'(DEPTH / 2);

  logic [NUM_EVT-1:0] set, clr;
  logic [LVL_W-1:0]   thr;
  logic               lvl_off;

  assign thr     = lvl_cfg[LVL_W-1:0];
  assign lvl_off = lvl_cfg[7];
  assign clr     = we_sts ? mask_wdata : '0;

  always_comb begin
    set          = '0;
    set[EV_LVL2] = commit && !lvl_off && (thr != '0) && (ptr_nxt == PTR_W'(thr));
    set[EV_DESEL]= cs_rise;
    set[EV_SEL]  = cs_fall;
    set[EV_HALF] = commit && (ptr_nxt == HALF_PTR);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts     <= '0;
      en      <= '0;
      lvl_cfg <= 8'h80;
      irq     <= 1'b0;
    end else begin
      sts <= (sts & ~clr) | set;
      irq <= |(sts & en);
      if (we_en)  en      <= mask_wdata;
      if (we_lvl) lvl_cfg <= lvl_wdata;
    end
  end

  p_desel_event_r5: assert property (@(posedge clk) disable iff (rst)
    cs_rise |=> sts[EV_DESEL]);
  p_lvl2_armed_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(sts[EV_LVL2]) |-> !$past(lvl_off));
  p_w1c_r8: assert property (@(posedge clk) disable iff (rst)
    (we_sts && set == '0) |=> ((sts & $past(mask_wdata)) == '0));
  p_masked_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (en == '0) |=> !irq);
endmodule

// File: rtl/spi_tgt_evt.sv
module spi_tgt_evt
  import spi_tgt_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int LVL_W = 6,
  parameter int SYNC_STAGES = 2,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int ADDR_W = PTR_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_cs_n,
  input  logic              spi_sclk,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_we,
  input  logic              cpu_re,
  output logic [7:0]        cpu_rdata,
  output logic              irq
);
  logic             cs_n_q, cs_fall, cs_rise, sclk_rise, mosi_q;
  logic [PTR_W-1:0] ptr, ptr_nxt;
  logic             commit;
  logic [7:0]       rx_byte, ob_q, reg_val, lvl_cfg;
  logic [NUM_EVT-1:0] sts, en;
  logic [7:0]       ibuf_mem [DEPTH];
  logic [7:0]       obuf_mem [DEPTH];
  rgn_e             rgn;
  reg_sel_e         rsel;
  logic             wr_regs;

  assign rgn     = rgn_e'(cpu_addr[ADDR_W-1 -: 2]);
  assign rsel    = reg_sel_e'(cpu_addr[1:0]);
  assign wr_regs = cpu_we && (rgn == RGN_REGS);

  spi_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk, .rst,
    .cs_n_pin(spi_cs_n), .sclk_pin(spi_sclk), .mosi_pin(spi_mosi),
    .cs_n_q, .cs_fall, .cs_rise, .sclk_rise, .mosi_q
  );

  spi_tgt_shift #(.DEPTH(DEPTH)) u_shift (
    .clk, .rst, .cs_n_q, .cs_fall, .sclk_rise, .mosi_q,
    .ob_byte(ob_q), .ptr, .ptr_nxt, .commit, .rx_byte, .miso(spi_miso)
  );

  spi_tgt_events #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_evt (
    .clk, .rst, .cs_fall, .cs_rise, .commit, .ptr_nxt,
    .we_sts(wr_regs && rsel == RS_STATUS),
    .we_en (wr_regs && rsel == RS_ENABLE),
    .we_lvl(wr_regs && rsel == RS_LEVEL),
    .mask_wdata(cpu_wdata[NUM_EVT-1:0]),
    .lvl_wdata(cpu_wdata),
    .sts, .en, .lvl_cfg, .irq
  );

  // Input buffer: serial side writes, CPU side reads.
  always_ff @(posedge clk) begin
    if (commit) ibuf_mem[ptr] <= rx_byte;
  end

  // Output buffer: CPU side writes, serial side reads at the transfer pointer.
  always_ff @(posedge clk) begin
    if (cpu_we && rgn == RGN_OBUF) obuf_mem[cpu_addr[PTR_W-1:0]] <= cpu_wdata;
    ob_q <= obuf_mem[ptr];
  end

  always_comb begin
    case (rsel)
      RS_STATUS: reg_val = 8'(sts);
      RS_ENABLE: reg_val = 8'(en);
      RS_LEVEL:  reg_val = lvl_cfg;
      default:   reg_val = 8'(ptr) | (cs_n_q ? 8'h00 : 8'h80);
    endcase
  end

  always_ff @(posedge clk) begin
    if (cpu_re) begin
      case (rgn)
        RGN_IBUF: cpu_rdata <= ibuf_mem[cpu_addr[PTR_W-1:0]];
        RGN_REGS: cpu_rdata <= reg_val;
        default:  cpu_rdata <= 8'h00;
      endcase
    end
  end

  p_idle_ptr_r10: assert property (@(posedge clk) disable iff (rst)
    (cs_n_q && !cs_fall && $past(cs_n_q)) |=> $stable(ptr));
endmodule

// File: tb/spi_tgt_evt_tb_top.sv
module spi_tgt_evt_tb_top;
  localparam int A_IBUF = 128, A_STS = 256, A_EN = 257, A_CFG = 258, A_STATE = 259;

  logic clk = 0, rst = 1;
  logic cs_n = 1, sclk = 0, mosi = 0;
  logic [8:0] addr = 0;
  logic [7:0] wdata = 0;
  logic we = 0, re = 0;
  logic miso, irq;
  logic [7:0] rdata;

  int n_chk = 0, n_fail = 0;
  bit started = 0, done = 0;

  always #10 clk = ~clk;

  spi_tgt_evt dut_i (
    .clk, .rst, .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_mosi(mosi), .spi_miso(miso),
    .cpu_addr(addr), .cpu_wdata(wdata), .cpu_we(we), .cpu_re(re), .cpu_rdata(rdata), .irq
  );

  // Reference model: raw pin view, delayed into the block's two-flop timeline.
  logic [7:0] m_ibuf [128];
  logic [7:0] m_obuf [128];
  logic [3:0] m_sts = 0, m_en = 0, sh0 = 0, sh1 = 0, s, clr;
  logic [7:0] m_cfg = 8'h80, m_sh = 0, exp_rdata = 0;
  int m_bit = 0, m_ptr = 0, ph0 = 0, ph1 = 0, ph2 = 0;
  logic ch0 = 1, ch1 = 1, r_cs = 1, r_sclk = 0, exp_irq = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_sts = 0; m_en = 0; m_cfg = 8'h80; m_bit = 0; m_ptr = 0; m_sh = 0;
      ph0 = 0; ph1 = 0; ph2 = 0; ch0 = 1; ch1 = 1; sh0 = 0; sh1 = 0;
      r_cs = 1; r_sclk = 0; exp_irq = 0;
    end else begin
      exp_irq = |(m_sts & m_en);
      if (re) begin
        if (addr >= A_IBUF && addr < A_STS) exp_rdata = m_ibuf[addr - A_IBUF];
        else if (addr == A_STS) exp_rdata = {4'h0, m_sts};
        else if (addr == A_EN) exp_rdata = {4'h0, m_en};
        else if (addr == A_CFG) exp_rdata = m_cfg;
        else if (addr == A_STATE) exp_rdata = 8'(ph2) | (ch1 ? 8'h00 : 8'h80);
        else exp_rdata = 0;
      end
      clr = 0;
      if (we) begin
        if (addr < A_IBUF) m_obuf[addr] = wdata;
        else if (addr == A_STS) clr = wdata[3:0];
        else if (addr == A_EN) m_en = wdata[3:0];
        else if (addr == A_CFG) m_cfg = wdata;
      end
      m_sts = (m_sts & ~clr) | sh1;
      sh1 = sh0; ph2 = ph1; ph1 = ph0; ch1 = ch0;
      s = 0;
      if (r_cs && !cs_n) begin m_bit = 0; m_ptr = 0; m_sh = 0; s[2] = 1; end
      else if (!r_cs && cs_n) s[1] = 1;
      else if (!cs_n && !r_sclk && sclk) begin
        m_sh = {m_sh[6:0], mosi};
        m_bit++;
        if (m_bit == 8) begin
          m_bit = 0;
          m_ibuf[m_ptr] = m_sh;
          m_ptr = (m_ptr + 1) % 128;
          if (m_ptr == 64) s[3] = 1;
          if (!m_cfg[7] && m_cfg[5:0] != 0 && m_ptr == int'(m_cfg[5:0])) s[0] = 1;
        end
      end
      sh0 = s; ph0 = m_ptr; ch0 = cs_n; r_cs = cs_n; r_sclk = sclk;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R9: interrupt compared against the model on every clock
  always @(negedge clk) if (started && !done) chk("R9 irq per clock", irq, exp_irq);

  task automatic wr(int a, int d);
    @(negedge clk); addr = 9'(a); wdata = 8'(d); we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(int a, string tag, output logic [7:0] v);
    @(negedge clk); addr = 9'(a); re = 1;
    @(negedge clk); re = 0;
    v = rdata;
    chk(tag, rdata, exp_rdata);
  endtask

  task automatic rd_exp(int a, string tag, int exp);
    logic [7:0] v;
    rd(a, tag, v);
    chk(tag, v, exp);
  endtask

  task automatic sel();
    @(negedge clk); cs_n = 0; repeat (8) @(negedge clk);
  endtask
  task automatic desel();
    @(negedge clk); cs_n = 1; repeat (6) @(negedge clk);
  endtask

  task automatic send_bit(logic b);
    @(negedge clk); sclk = 0; mosi = b; repeat (6) @(negedge clk);
    sclk = 1; repeat (5) @(negedge clk);
    sclk = 0;
  endtask

  task automatic send_byte(logic [7:0] d, int idx);
    for (int b = 7; b >= 0; b--) begin
      @(negedge clk); sclk = 0; mosi = d[b]; repeat (6) @(negedge clk);
      chk("R11 miso bit", miso, m_obuf[idx % 128][b]);
      sclk = 1; repeat (5) @(negedge clk);
    end
    @(negedge clk); sclk = 0;
  endtask

  function automatic logic [7:0] pat(int i);
    return 8'((i * 29 + 8'h5A) ^ (i >> 2));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst = 0;
    started = 1;
    // R1 reset state
    rd_exp(A_STS, "R1 status", 8'h00);
    rd_exp(A_EN, "R1 enable", 8'h00);
    rd_exp(A_CFG, "R1 level", 8'h80);
    rd_exp(A_STATE, "R1 state", 8'h00);
    chk("R1 irq", irq, 0);

    wr(A_EN, 8'h0F);
    for (int i = 0; i < 128; i++) wr(i, 8'(i * 53 + 7));

    // R2 basic transfer, R10 busy and pointer mid-transfer
    sel();
    for (int i = 0; i < 10; i++) begin
      send_byte(pat(i), i);
      if (i == 4) rd_exp(A_STATE, "R10 busy with pointer 5", 8'h85);
    end
    desel();
    rd_exp(A_STATE, "R10 idle", 8'h0A);
    for (int i = 0; i < 10; i++) rd_exp(A_IBUF + i, "R2 input byte", pat(i));
    rd_exp(A_STS, "R4 R5 select and release events", 8'h06);

    // R8 write-one-to-clear
    wr(A_STS, 8'h00);
    rd_exp(A_STS, "R8 zero write keeps bits", 8'h06);
    wr(A_STS, 8'h02);
    rd_exp(A_STS, "R8 clears only bit1", 8'h04);
    wr(A_STS, 8'h0F);
    rd_exp(A_STS, "R8 all cleared", 8'h00);

    // R5 select window without SCLK
    sel(); desel();
    rd_exp(A_STS, "R5 release without clocks", 8'h06);
    wr(A_STS, 8'h0F);

    // R4 partial byte discarded by a new select
    sel();
    send_bit(1); send_bit(0); send_bit(1);
    desel();
    sel();
    send_byte(8'h3C, 0);
    rd_exp(A_STATE, "R4 pointer restarted", 8'h81);
    desel();
    rd_exp(A_IBUF, "R4 fresh byte aligned", 8'h3C);
    wr(A_STS, 8'h0F);

    // R7 second level at threshold 8
    wr(A_CFG, 8'h88);
    wr(A_CFG, 8'h08);
    rd_exp(A_CFG, "R7 level readback", 8'h08);
    sel();
    for (int i = 0; i < 7; i++) send_byte(pat(i + 40), i);
    repeat (4) @(negedge clk);
    rd_exp(A_STS, "R7 below threshold", 8'h04);
    send_byte(pat(47), 7);
    repeat (4) @(negedge clk);
    rd_exp(A_STS, "R7 threshold reached", 8'h05);
    desel();
    wr(A_STS, 8'h0F);

    // R7 threshold zero never fires
    wr(A_CFG, 8'h80);
    wr(A_CFG, 8'h00);
    sel();
    for (int i = 0; i < 9; i++) send_byte(pat(i + 60), i);
    desel();
    rd_exp(A_STS, "R7 zero threshold silent", 8'h06);
    wr(A_STS, 8'h0F);

    // R7 disabled threshold never fires
    wr(A_CFG, 8'h85);
    sel();
    for (int i = 0; i < 6; i++) send_byte(pat(i + 70), i);
    desel();
    rd_exp(A_STS, "R7 disabled level silent", 8'h06);
    wr(A_STS, 8'h0F);

    // R6 half mark, R3 and R11 wrap
    sel();
    for (int i = 0; i < 64; i++) send_byte(pat(i + 100), i);
    repeat (4) @(negedge clk);
    rd_exp(A_STS, "R6 half mark", 8'h0C);
    for (int i = 64; i < 130; i++) send_byte(pat(i + 100), i);
    rd_exp(A_STATE, "R3 pointer wrapped to 2", 8'h82);
    desel();
    rd_exp(A_IBUF + 0, "R3 overwrite loc 0", pat(228));
    rd_exp(A_IBUF + 1, "R3 overwrite loc 1", pat(229));
    rd_exp(A_IBUF + 2, "R3 loc 2 kept", pat(102));
    rd_exp(A_IBUF + 127, "R3 last loc", pat(227));
    rd_exp(A_STS, "R6 status after wrap", 8'h0E);

    // R9 enable masking
    wr(A_EN, 8'h00);
    repeat (3) @(negedge clk);
    chk("R9 masked irq low", irq, 0);
    wr(A_EN, 8'h02);
    repeat (3) @(negedge clk);
    chk("R9 enabled irq high", irq, 1);
    wr(A_STS, 8'h02);
    repeat (3) @(negedge clk);
    chk("R9 irq drops after clear", irq, 0);
    rd(A_STS, "R8 other bits kept", v);
    chk("R8 other bits kept", v, 8'h0C);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule